// File: doc/BRIEF.md
# Per-Port Programmed-I/O Credit Tracker

This block keeps one credit-tracking register for each of nine programmed-I/O destinations. Entry 0 stands for the local internal space. Entries 1 to 8 stand for external ports 8 through 15. Each entry holds an 8-bit credit count. A request sent to the port takes one credit, and a response coming back returns one.

When software writes an entry, it sets the credit count. The same value is also kept in a hidden shadow register that software cannot read. If the count ever climbs above that shadow, more responses have come back than requests were sent. The entry then raises a sticky spurious-response flag, and only another software write to that entry can lower it.

Beside the counter, each entry stores several descriptive fields exactly as software writes them. It also keeps a small set of error indications: an error summary, a multiple-error flag and a saturating underflow counter. A per-port clear strobe wipes these error indications. A read returns the whole 64-bit image of the entry chosen by the read index, with no clock delay.

Top module: `pio_credit_bank`

## Requirements
- R1: After reset, every entry has a count of 0 and a shadow of 0. Every entry reads as all zeros, and `spur_flag` and `err_flag` are 0.
- R2: Image layout, by bit position:
  - count: [7:0]
  - field A: [21:8]
  - field B: [37:24]
  - mode: [41:40]
  - flag: [42]
  - underflow count: [47:43]
  - error: [48]
  - read time-out: [49]
  - spurious response: [50]
  - spurious read: [51]
  - multiple error: [63]
- R3: Bits [23:22], [39:38] and [62:52] always read 0, whatever was written. A read index of 9 or more returns 0.
- R4: A write with `wr_en` to entry `wr_idx` does the following:
  - It loads count, field A, field B, mode, flag, read time-out and spurious read from `wr_data`.
  - It copies the new count into the shadow.
  - It clears the spurious-response bit.
  - It leaves error, multiple error and the underflow count unchanged.
- R5: A request strobe alone lowers the count by 1. A response strobe alone raises it by 1. Both strobes in the same cycle leave the count unchanged and cannot set the spurious-response bit.
- R6: The count saturates at 255 and at 0. A request at count 0 adds 1 to the underflow count, which saturates at 31.
- R7: The spurious-response bit sets in the cycle a response (without a request) raises the count to a value greater than the shadow. It then stays set until the entry is written, and the clear strobe does not clear it.
- R8: The error bit sets on a new error event: the spurious-response bit rising, or a request at count 0. If the error bit was already set, the event also sets the multiple-error bit.
- R9: A clear strobe zeroes error, read time-out, spurious read, underflow count and multiple error one cycle later. An error event in the same cycle still sets error, and the underflow count becomes 1 if that event is an underflow.
- R10: A write to an entry takes priority over that entry's request, response and clear strobes in the same cycle. Those strobes are then ignored.
- R11: `spur_flag[i]` and `err_flag[i]` equal entry i's spurious-response and error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Entry selected for the write |
| wr_data | input | 64 | Write image |
| rd_idx | input | 4 | Entry selected for the read |
| rd_data | output | 64 | Image of the selected entry, combinational |
| req_issue | input | 9 | Per-entry request-sent strobes |
| rsp_return | input | 9 | Per-entry response-returned strobes |
| err_clr | input | 9 | Per-entry error-clear strobes |
| spur_flag | output | 9 | Per-entry spurious-response status |
| err_flag | output | 9 | Per-entry error status |

## Verification
The bench targets these corner cases and the faults each one would expose:
- **Count returns exactly to the shadow.** This must stay clean; a design using `>=` instead of `>` would flag it.
- **Count rises one above the shadow.** This must flag; a design that never compares against the shadow would stay silent.
- **Count saturated at 255 with a shadow of 255.** A response here must not flag; a design that wraps would read 0.
- **Clear strobe on an entry with the spurious-response bit set.** The bit must survive; a design that clears it with the other error bits would drop it.
- **Underflow repeated past 31.** This exercises the multiple-error bit and the underflow-count saturation.
- **Write in the same cycle as strobes on that entry.** The write must win; a design that applied the strobes after the write would move the count away from the written value.

// File: rtl/pio_credit_pkg.sv
package pio_credit_pkg;
  localparam int REG_W  = 64;
  localparam int CRED_W = 8;
  localparam int FA_W   = 14;
  localparam int FB_W   = 14;
  localparam int MODE_W = 2;
  localparam int UFC_W  = 5;

  // Image bit positions (the image is the software-visible register)
  localparam int P_CRED = 0;
  localparam int P_FA   = 8;
  localparam int P_FB   = 24;
  localparam int P_MODE = 40;
  localparam int P_FLAG = 42;
  localparam int P_UFC  = 43;
  localparam int P_ERR  = 48;
  localparam int P_RDTO = 49;
  localparam int P_SPW  = 50;
  localparam int P_SPR  = 51;
  localparam int P_MULT = 63;

  localparam logic [REG_W-1:0] RSV_MASK = 64'h7FF0_00C0_00C0_0000;

  typedef struct packed {
    logic [CRED_W-1:0] cred;
    logic [FA_W-1:0]   fa;
    logic [FB_W-1:0]   fb;
    logic [MODE_W-1:0] mode;
    logic              flag;
    logic [UFC_W-1:0]  ufc;
    logic              err;
    logic              rdto;
    logic              spw;
    logic              spr;
    logic              mult;
  } entry_t;

  function automatic logic [REG_W-1:0] pack_image(input entry_t e);
    logic [REG_W-1:0] v;
    v = '0;
    v[P_CRED +: CRED_W] = e.cred;
    v[P_FA   +: FA_W]   = e.fa;
    v[P_FB   +: FB_W]   = e.fb;
    v[P_MODE +: MODE_W] = e.mode;
    v[P_FLAG]           = e.flag;
    v[P_UFC  +: UFC_W]  = e.ufc;
    v[P_ERR]            = e.err;
    v[P_RDTO]           = e.rdto;
    v[P_SPW]            = e.spw;
    v[P_SPR]            = e.spr;
    v[P_MULT]           = e.mult;
    return v;
  endfunction

  function automatic logic [CRED_W-1:0] cred_up(input logic [CRED_W-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  function automatic logic [CRED_W-1:0] cred_dn(input logic [CRED_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [UFC_W-1:0] ufc_up(input logic [UFC_W-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction
endpackage

// File: rtl/pio_credit_entry.sv
module pio_credit_entry
  import pio_credit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             req,
  input  logic             rsp,
  input  logic             clr,
  output logic [REG_W-1:0] image,
  output logic             spur_rise,
  output logic             uflow
);
  entry_t            st;
  logic [CRED_W-1:0] shadow;
  logic              inc, dec, evt;
  logic              err_base, mult_base;
  logic [UFC_W-1:0]  ufc_base;

  assign inc       = rsp & ~req;
  assign dec       = req & ~rsp;
  assign spur_rise = ~wr_sel & inc & (st.cred != '1) & ~st.spw
                     & (cred_up(st.cred) > shadow);
  assign uflow     = ~wr_sel & dec & (st.cred == '0);
  assign evt       = spur_rise | uflow;
  assign err_base  = clr ? 1'b0 : st.err;
  assign mult_base = clr ? 1'b0 : st.mult;
  assign ufc_base  = clr ? '0 : st.ufc;
  assign image     = pack_image(st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= '0;
      shadow <= '0;
    end else if (wr_sel) begin
      st.cred <= wr_data[P_CRED +: CRED_W];
      shadow  <= wr_data[P_CRED +: CRED_W];
      st.fa   <= wr_data[P_FA +: FA_W];
      st.fb   <= wr_data[P_FB +: FB_W];
      st.mode <= wr_data[P_MODE +: MODE_W];
      st.flag <= wr_data[P_FLAG];
      st.rdto <= wr_data[P_RDTO];
      st.spr  <= wr_data[P_SPR];
      st.spw  <= 1'b0;
    end else begin
      if (inc)       st.cred <= cred_up(st.cred);
      else if (dec)  st.cred <= cred_dn(st.cred);
      if (spur_rise) st.spw  <= 1'b1;
      st.err  <= err_base | evt;
      st.mult <= mult_base | (evt & err_base);
      st.ufc  <= uflow ? ufc_up(ufc_base) : ufc_base;
      if (clr) begin
        st.rdto <= 1'b0;
        st.spr  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pio_credit_rdsel.sv
module pio_credit_rdsel
  import pio_credit_pkg::*;
#(
  parameter int N_ENT = 9,
  parameter int IDX_W = 4
) (
  input  logic [N_ENT-1:0][REG_W-1:0] images,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [REG_W-1:0]            rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_ENT; i++)
      if (rd_idx == IDX_W'(i)) rd_data = images[i];
  end
endmodule

// File: rtl/pio_credit_bank.sv
module pio_credit_bank
  import pio_credit_pkg::*;
#(
  parameter int N_ENT = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_ENT-1:0] req_issue,
  input  logic [N_ENT-1:0] rsp_return,
  input  logic [N_ENT-1:0] err_clr,
  output logic [N_ENT-1:0] spur_flag,
  output logic [N_ENT-1:0] err_flag
);
  logic [N_ENT-1:0][REG_W-1:0] images;
  logic [N_ENT-1:0]            wr_sel;
  logic [N_ENT-1:0]            spur_rise_ev;
  logic [N_ENT-1:0]            uflow_ev;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
    pio_credit_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_sel[g]),
      .wr_data   (wr_data),
      .req       (req_issue[g]),
      .rsp       (rsp_return[g]),
      .clr       (err_clr[g]),
      .image     (images[g]),
      .spur_rise (spur_rise_ev[g]),
      .uflow     (uflow_ev[g])
    );
    assign spur_flag[g] = images[g][P_SPW];
    assign err_flag[g]  = images[g][P_ERR];
  end

  pio_credit_rdsel #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_rd (
    .images  (images),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/pio_credit_bank_chk.sv
module pio_credit_bank_chk
  import pio_credit_pkg::*;
#(
  parameter int N_ENT = 9,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [REG_W-1:0] rd_data,
  input logic [N_ENT-1:0] req_issue,
  input logic [N_ENT-1:0] rsp_return,
  input logic [N_ENT-1:0] spur_flag,
  input logic [N_ENT-1:0] err_flag,
  input logic [N_ENT-1:0] spur_rise_ev,
  input logic [N_ENT-1:0] uflow_ev
);
  logic [N_ENT-1:0] wmask;
  always_comb
    for (int i = 0; i < N_ENT; i++) wmask[i] = wr_en && (wr_idx == IDX_W'(i));

  // R3
  a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSV_MASK) == '0);

  // R7: sticky unless written
  a_r7_spur_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((spur_flag & $past(spur_flag & ~wmask)) == $past(spur_flag & ~wmask)));

  // R4: write clears the spurious bit
  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|wmask) |=> ((spur_flag & $past(wmask)) == '0));

  // R5: a rise needs a lone response in the previous cycle
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((spur_flag & ~$past(spur_flag) & ~$past(rsp_return & ~req_issue)) == '0));

  // R8: error events set the error bit
  a_r8_err_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|(spur_rise_ev | uflow_ev)) |=>
      ((err_flag & $past(spur_rise_ev | uflow_ev)) == $past(spur_rise_ev | uflow_ev)));
endmodule

bind pio_credit_bank pio_credit_bank_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .rd_data      (rd_data),
  .req_issue    (req_issue),
  .rsp_return   (rsp_return),
  .spur_flag    (spur_flag),
  .err_flag     (err_flag),
  .spur_rise_ev (spur_rise_ev),
  .uflow_ev     (uflow_ev)
);

// File: tb/sim_pio_credit_bank.sv
module sim_pio_credit_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic [8:0]  req_issue = '0, rsp_return = '0, err_clr = '0;
  logic [8:0]  spur_flag, err_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          idx;
    logic [63:0] data;
    logic        spw;
    logic        err;
    int          rq;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  pio_credit_bank u0 (.*);

  localparam logic [63:0] RSV = 64'h7FF0_00C0_00C0_0000;

  function automatic logic [63:0] img(input int c, na, nb, m, f, of, er, rt, sw, sr, mu);
    logic [63:0] v;
    v = 64'(c & 255) | (64'(na & 16'h3FFF) << 8) | (64'(nb & 16'h3FFF) << 24)
      | (64'(m & 3) << 40) | (64'(f & 1) << 42) | (64'(of & 31) << 43)
      | (64'(er & 1) << 48) | (64'(rt & 1) << 49) | (64'(sw & 1) << 50)
      | (64'(sr & 1) << 51) | (64'(mu & 1) << 63);
    return v;
  endfunction

  // entry 2 with its stored descriptive fields
  function automatic logic [63:0] e2(input int c, er, rt, sw, sr);
    return img(c, 16'h1234, 16'h2ABC, 2, 1, 0, er, rt, sw, sr, 0);
  endfunction

  task automatic step(input logic we, input int wi, input logic [63:0] wd,
                      input logic [8:0] rq, input logic [8:0] rs, input logic [8:0] cl);
    wr_en = we; wr_idx = wi[3:0]; wr_data = wd;
    req_issue = rq; rsp_return = rs; err_clr = cl;
    @(negedge clk);
    wr_en = 1'b0; req_issue = '0; rsp_return = '0; err_clr = '0;
  endtask

  task automatic expect_reg(input int idx, input logic [63:0] d, input logic sw,
                            input logic er, input int rq);
    item_t it;
    rd_idx = idx[3:0];
    it.idx = idx; it.data = d; it.spw = sw; it.err = er; it.rq = rq;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares after the read index has settled
  initial forever begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (rd_data !== it.data) begin
        n_fail++;
        $display("FAIL R%0d entry %0d image actual=%h expected=%h", it.rq, it.idx, rd_data, it.data);
      end
      if (it.idx < 9 && (spur_flag[it.idx] !== it.spw || err_flag[it.idx] !== it.err)) begin
        n_fail++;
        $display("FAIL R11 entry %0d flags actual=%b%b expected=%b%b", it.idx,
                 spur_flag[it.idx], err_flag[it.idx], it.spw, it.err);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    expect_reg(0, 64'h0, 0, 0, 1);
    expect_reg(4, 64'h0, 0, 0, 1);
    expect_reg(8, 64'h0, 0, 0, 1);
    // R3: out-of-range index
    expect_reg(9, 64'h0, 0, 0, 3);

    // R2 R3 R4: write with every bit set that must not stick
    step(1, 2, img(5, 16'h1234, 16'h2ABC, 2, 1, 31, 1, 1, 1, 1, 1) | RSV, '0, '0, '0);
    expect_reg(2, e2(5, 0, 1, 0, 1), 0, 0, 2);

    // R5: request lowers, both together hold
    step(0, 0, '0, 9'h004, '0, '0);
    step(0, 0, '0, 9'h004, '0, '0);
    expect_reg(2, e2(3, 0, 1, 0, 1), 0, 0, 5);
    step(0, 0, '0, 9'h004, 9'h004, '0);
    expect_reg(2, e2(3, 0, 1, 0, 1), 0, 0, 5);
    // R7: back to the shadow exactly, no flag
    step(0, 0, '0, '0, 9'h004, '0);
    step(0, 0, '0, '0, 9'h004, '0);
    expect_reg(2, e2(5, 0, 1, 0, 1), 0, 0, 7);
    // R7 R8: one above the shadow
    step(0, 0, '0, '0, 9'h004, '0);
    expect_reg(2, e2(6, 1, 1, 1, 1), 1, 1, 7);
    // R9 R7: clear keeps the spurious bit
    step(0, 0, '0, '0, '0, 9'h004);
    expect_reg(2, e2(6, 0, 0, 1, 0), 1, 0, 9);
    // R8: further response is no new event
    step(0, 0, '0, '0, 9'h004, '0);
    expect_reg(2, e2(7, 0, 0, 1, 0), 1, 0, 8);
    // R4: write lowers the spurious bit
    step(1, 2, img(7, 16'h1234, 16'h2ABC, 2, 1, 0, 0, 0, 0, 0, 0), '0, '0, '0);
    expect_reg(2, e2(7, 0, 0, 0, 0), 0, 0, 4);

    // R6 R8: underflow on entry 5
    step(0, 0, '0, 9'h020, '0, '0);
    expect_reg(5, img(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0), 0, 1, 6);
    step(0, 0, '0, 9'h020, '0, '0);
    expect_reg(5, img(0, 0, 0, 0, 0, 2, 1, 0, 0, 0, 1), 0, 1, 8);
    // R9: clear with a simultaneous underflow
    step(0, 0, '0, 9'h020, '0, 9'h020);
    expect_reg(5, img(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0), 0, 1, 9);

    // R6: underflow count saturates at 31
    for (int k = 0; k < 33; k++) step(0, 0, '0, 9'h040, '0, '0);
    expect_reg(6, img(0, 0, 0, 0, 0, 31, 1, 0, 0, 0, 1), 0, 1, 6);

    // R6 R7: count held at 255, shadow 255, no flag
    step(1, 7, img(255, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0, '0, '0);
    step(0, 0, '0, '0, 9'h080, '0);
    expect_reg(7, img(255, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 6);

    // R7 R8: first response after reset exceeds shadow 0
    step(0, 0, '0, '0, 9'h001, '0);
    expect_reg(0, img(1, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0), 1, 1, 7);
    // R10: write beats response and clear on the same entry
    step(1, 0, img(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0, 9'h001, 9'h001);
    expect_reg(0, img(4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0), 0, 1, 10);
    // R10: write beats request on entry 3
    step(1, 3, img(10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 9'h008, '0, '0);
    expect_reg(3, img(10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 10);

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule